// File: doc/BRIEF.md
# Serial Readback Response Transmitter

This block is the talk-back half of a three-wire serial control port (shift clock, shared data line, latch strobe). The command decoder elsewhere pulses a read-request strobe when it recognises a read command. The transmitter holds that request until the latch strobe rises, which closes the command frame. At that moment it captures the reply contents. It then leaves the data line undriven for a fixed number of shift-clock rising edges so that the bus master can release the line. After that it drives a 24-bit reply: a header byte, then the first result byte, then the second result byte.

All logic runs on a fast system clock. The shift clock and the latch strobe are treated as level inputs that are already synchronous to that clock. Their rising edges are found by sampling. The serial output and its enable are registered. Each reply bit is held for a full shift-clock period. The enable goes to the pad tristate control.

The reply contents are loaded in one cycle, at the latch edge. No valid/ready handshake is needed, and back-pressure does not apply. The sources must simply hold stable values while the latch rises.

Top module: `rb_readback_tx`

## Requirements
- R1: After reset, and whenever no reply is being driven, `sdo_oe` is 0 and `sdo` is 0.
- R2: A latch rising edge with no pending read request leaves `sdo_oe` at 0 for the whole following window.
- R3: The first reply bit is presented, with `sdo_oe` rising, on the fifth shift-clock rising edge after the latch rising edge (TURN_EDGES = 5).
- R4: The reply is the header byte, then `result1`, then `result2`, each byte most significant bit first. Each later bit appears on the next shift-clock rising edge, and `sdo` changes at no other time while driven.
- R5: The header byte, from MSB to LSB, is 1, 0, 1, 0, src_code[1], src_code[0], lock_det, 0.
- R6: `src_code`, `lock_det`, `result1` and `result2` are sampled at the latch rising edge. Changes after that edge do not alter the reply.
- R7: `sdo_oe` drops on the shift-clock rising edge that follows the edge presenting the last bit of `result2`. The line is therefore driven for exactly 24 shift-clock periods.
- R8: A latch rising edge during a turnaround or reply aborts it, and `sdo_oe` is 0 from the next cycle. If a read request is pending at that edge, a fresh reply is started with the full turnaround and newly sampled contents.
- R9: A `rd_req` pulse stays pending across any number of shift-clock edges until the next latch rising edge. That edge consumes it, so a later latch edge with no new request produces no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock level |
| ser_latch | input | 1 | Serial latch strobe level |
| rd_req | input | 1 | One-cycle read request from the command decoder |
| src_code | input | 2 | Result source identifier placed in the header |
| lock_det | input | 1 | Synthesiser lock status placed in the header |
| result1 | input | 8 | First result byte |
| result2 | input | 8 | Second result byte |
| sdo | output | 1 | Serial reply data |
| sdo_oe | output | 1 | Output enable for the data pad tristate |

## Verification
The bench counts turnaround edges precisely. A design that is off by one edge would put the header one bit early or late, and every later bit would then miscompare. The source inputs are changed right after the latch to catch a design that reads live inputs rather than a snapshot. Back-to-back latches cover three cases: a latch with no request, which must produce no reply; an abort with no request, where a broken design would keep driving the shared line; and an abort with a new request, where a broken design would resume the old frame or skip the turnaround. A request is also left pending over idle shift edges, to catch a design that loses it or reuses it.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_SEND = 2'd2
  } rb_state_e;
endpackage

// File: rtl/rb_edge_detect.sv
`timescale 1ns/1ps
module rb_edge_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q;
  end
endmodule

// File: rtl/rb_frame_capture.sv
`timescale 1ns/1ps
module rb_frame_capture #(
  parameter int          WORD_W   = 8,
  parameter int          SYNC_W   = 4,
  parameter logic [3:0]  SYNC_PAT = 4'b1010,
  localparam int         FRAME_W  = 3 * WORD_W,
  localparam int         PAD_W    = WORD_W - SYNC_W - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         src_code,
  input  logic               lock_det,
  input  logic [WORD_W-1:0]  result1,
  input  logic [WORD_W-1:0]  result2,
  output logic [FRAME_W-1:0] frame
);
  logic [WORD_W-1:0] header;

  // header: sync pattern, source id, lock status, zero padding in the low bits
  always_comb begin
    header = WORD_W'({SYNC_PAT[SYNC_W-1:0], src_code, lock_det}) << PAD_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frame <= '0;
    else if (load) frame <= {header, result1, result2};
  end

  // R6: snapshot only moves at a capture strobe
  p_snapshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(frame));
endmodule

// File: rtl/rb_shift_ctrl.sv
`timescale 1ns/1ps
module rb_shift_ctrl
  import rb_pkg::*;
#(
  parameter int FRAME_W    = 24,
  parameter int TURN_EDGES = 5,
  localparam int TC_W      = $clog2(TURN_EDGES + 1),
  localparam int BC_W      = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cl_rise,
  input  logic               lat_rise,
  input  logic               rd_req,
  input  logic [FRAME_W-1:0] frame,
  output logic               load,
  output logic               sdo,
  output logic               sdo_oe
);
  rb_state_e          state;
  logic               pending;
  logic [TC_W-1:0]    turn_cnt;
  logic [BC_W-1:0]    bit_cnt;
  logic [FRAME_W-1:0] shreg;

  assign load = lat_rise & (pending | rd_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pending  <= 1'b0;
      turn_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else if (lat_rise) begin
      pending  <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      turn_cnt <= '0;
      bit_cnt  <= '0;
      state    <= load ? ST_TURN : ST_IDLE;
    end else begin
      if (rd_req) pending <= 1'b1;
      case (state)
        ST_TURN: if (cl_rise) begin
          if (turn_cnt == TC_W'(TURN_EDGES - 1)) begin
            state   <= ST_SEND;
            sdo_oe  <= 1'b1;
            sdo     <= frame[FRAME_W-1];
            shreg   <= frame << 1;
            bit_cnt <= BC_W'(1);
          end else begin
            turn_cnt <= turn_cnt + 1'b1;
          end
        end
        ST_SEND: if (cl_rise) begin
          if (bit_cnt == BC_W'(FRAME_W)) begin
            state  <= ST_IDLE;
            sdo_oe <= 1'b0;
            sdo    <= 1'b0;
          end else begin
            sdo     <= shreg[FRAME_W-1];
            shreg   <= shreg << 1;
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // checker-side count of shift edges seen while the line is driven
  logic [BC_W:0] oe_edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   oe_edges <= '0;
    else if (!sdo_oe)             oe_edges <= '0;
    else if (cl_rise && !lat_rise) oe_edges <= oe_edges + 1'b1;
  end

  p_quiet_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  p_no_req_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !pending && !rd_req) |=> !sdo_oe);
  p_first_bit_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(cl_rise));
  p_bit_on_cl_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> $past(cl_rise));
  p_drive_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_edges <= (BC_W+1)'(FRAME_W));
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> !sdo_oe);
endmodule

// File: rtl/rb_readback_tx.sv
`timescale 1ns/1ps
module rb_readback_tx #(
  parameter int WORD_W     = 8,
  parameter int TURN_EDGES = 5,
  localparam int FRAME_W   = 3 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_latch,
  input  logic              rd_req,
  input  logic [1:0]        src_code,
  input  logic              lock_det,
  input  logic [WORD_W-1:0] result1,
  input  logic [WORD_W-1:0] result2,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [1:0]         rises;
  logic               load;
  logic [FRAME_W-1:0] frame;

  rb_edge_detect #(.N(2)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({ser_latch, ser_clk}),
    .rise  (rises)
  );

  rb_frame_capture #(.WORD_W(WORD_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .src_code (src_code),
    .lock_det (lock_det),
    .result1  (result1),
    .result2  (result2),
    .frame    (frame)
  );

  rb_shift_ctrl #(.FRAME_W(FRAME_W), .TURN_EDGES(TURN_EDGES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl_rise  (rises[0]),
    .lat_rise (rises[1]),
    .rd_req   (rd_req),
    .frame    (frame),
    .load     (load),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );
endmodule

// File: tb/rb_readback_tx_test.sv
`timescale 1ns/1ps
module rb_readback_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TURN       = 5;

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_latch = 1'b0;
  logic       rd_req = 1'b0;
  logic [1:0] src_code = 2'b00;
  logic       lock_det = 1'b0;
  logic [7:0] result1 = 8'h00;
  logic [7:0] result2 = 8'h00;
  logic       sdo;
  logic       sdo_oe;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rb_readback_tx uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .rd_req(rd_req), .src_code(src_code), .lock_det(lock_det),
    .result1(result1), .result2(result2), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic push(input logic oe, input logic d, input string tag);
    exp_t e;
    e.oe = oe; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) push(1'b0, 1'b0, tag);
  endtask

  // expected per-shift-edge view of a full reply (30 edges)
  task automatic push_frame(input logic [1:0] s, input logic lk,
                            input logic [7:0] a, input logic [7:0] b);
    logic [23:0] f;
    f = {4'b1010, s, lk, 1'b0, a, b};
    push_idle(TURN - 1, "R3");
    for (int i = 23; i >= 0; i--)
      push(1'b1, f[i], (i >= 16) ? "R5" : "R4");
    push_idle(2, "R7");
  endtask

  task automatic cl_pulse();
    @(negedge clk) ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_edges(input int n);
    for (int i = 0; i < n; i++) cl_pulse();
  endtask

  task automatic request();
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
  endtask

  task automatic latch_with(input logic [1:0] s, input logic lk,
                            input logic [7:0] a, input logic [7:0] b);
    src_code = s; lock_det = lk; result1 = a; result2 = b;
    @(negedge clk) ser_latch = 1'b1;
    repeat (2) @(negedge clk);
    ser_latch = 1'b0;
    // R6: disturb sources right after the snapshot
    src_code = ~s; lock_det = ~lk; result1 = ~a; result2 = a ^ b ^ 8'h5A;
  endtask

  // monitor: compare mid high phase of every shift edge
  always @(posedge ser_clk) begin
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (sdo_oe !== e.oe || sdo !== e.d) begin
        n_fail++;
        $display("FAIL %s: oe/sdo actual %b/%b expected %b/%b",
                 e.tag, sdo_oe, sdo, e.oe, e.d);
      end
    end
  end

  task automatic check_direct(input string tag, input logic oe_e, input logic d_e);
    n_tests++;
    if (sdo_oe !== oe_e || sdo !== d_e) begin
      n_fail++;
      $display("FAIL %s: oe/sdo actual %b/%b expected %b/%b",
               tag, sdo_oe, sdo, oe_e, d_e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_direct("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_direct("R1", 1'b0, 1'b0);

    // R2: latch with no request
    latch_with(2'b11, 1'b1, 8'hAA, 8'h55);
    push_idle(30, "R2");
    run_edges(30);

    // R9: request held over idle shift edges, then normal reply (R3..R7)
    request();
    push_idle(3, "R9");
    run_edges(3);
    latch_with(2'b10, 1'b1, 8'hA5, 8'h3C);
    push_frame(2'b10, 1'b1, 8'hA5, 8'h3C);
    run_edges(30);

    // R9: request consumed, next latch alone gives nothing
    latch_with(2'b01, 1'b0, 8'h11, 8'h22);
    push_idle(30, "R9");
    run_edges(30);

    // second pattern
    request();
    latch_with(2'b01, 1'b0, 8'hFF, 8'h00);
    push_frame(2'b01, 1'b0, 8'hFF, 8'h00);
    run_edges(30);

    // R8: abort mid-reply with no new request
    request();
    latch_with(2'b00, 1'b1, 8'h81, 8'h7E);
    push_frame(2'b00, 1'b1, 8'h81, 8'h7E);
    run_edges(10);
    exp_q.delete();
    latch_with(2'b11, 1'b1, 8'hC3, 8'h99);
    check_direct("R8", 1'b0, 1'b0);
    push_idle(30, "R8");
    run_edges(30);

    // R8: abort with a new request restarts with new contents
    request();
    latch_with(2'b10, 1'b0, 8'h0F, 8'hF0);
    push_frame(2'b10, 1'b0, 8'h0F, 8'hF0);
    run_edges(12);
    exp_q.delete();
    request();
    latch_with(2'b11, 1'b1, 8'h69, 8'hB4);
    check_direct("R8", 1'b0, 1'b0);
    push_frame(2'b11, 1'b1, 8'h69, 8'hB4);
    run_edges(30);

    repeat (4) @(negedge clk);
    check_direct("R1", 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule